// File: doc/BRIEF.md
# Code-Mapped Clock Divider

This block produces a slower clock from its input clock. A 3-bit select code picks the divide ratio. The code does not feed a counter directly. A mapping fixed at elaboration turns it into a ratio, and the parameter `VARIANT` chooses which mapping applies. Some mappings give the same ratio for the two lowest codes. One mapping also yields odd ratios, so the generator handles both even and odd division.

The select code is sampled once per output period, on the last input cycle of that period. A ratio change therefore never cuts a high or low phase short, and the output never shows a short pulse. Every output period begins with its high phase. The output comes from a register. Choosing the source clock, storing the select field and gating the clock all happen outside this block.

Top module: `code_div_clk`

## Requirements
- R1: With `VARIANT` = 0 (quad step), code c selects ratio 4*(c+1), so codes 0 to 7 give 4 up to 32.
- R2: With `VARIANT` = 1 (double step), code c selects ratio 2*(c+1), so codes 0 to 7 give 2 up to 16.
- R3: With `VARIANT` = 2 (double step, floor 4), codes 0 and 1 both select ratio 4, and code c >= 2 selects 2*(c+1).
- R4: With `VARIANT` = 3 (unit step, floor 2), codes 0 and 1 both select ratio 2, and code c >= 2 selects c+1, which includes odd ratios. No mapping ever selects a ratio below 2.
- R5: For an even ratio N, the high phase and the low phase each last N/2 input cycles. For an odd ratio N, the high phase lasts (N+1)/2 cycles and the low phase lasts (N-1)/2 cycles.
- R6: `rst_i` is active-high and synchronous. At every rising clock edge where it is sampled high, `clk_div_o` becomes 0, whatever the select code does.
- R7: On the first rising edge after reset is released, the output goes high. That first period uses the ratio of the code that was present at the last reset edge.
- R8: A new code takes effect only at a period boundary. The period in progress always finishes with its old ratio. A code that is present on the last input cycle of a period sets the ratio of the next period.
- R9: Each output period starts with a rising output, and the phase counter is at its second count when that rise happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_code_i | input | 3 | Select code, translated through the variant mapping |
| clk_div_o | output | 1 | Divided clock, driven from a register |

## Verification
The assertions take three things for granted. First, `sel_code_i` is synchronous to `clk_i` and holds a known value at every sampled edge. Second, reset is asserted from time zero for at least one edge. Third, the mapping never produces a ratio that overflows the counter width. The stimulus drives the select code and reset only at falling edges and holds reset high from the start. It waits two full output rises after a code change before it measures a period, except in the tests that probe code changes inside a period on purpose.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    localparam int SEL_W   = 3;
    localparam int RATIO_W = 6;

    typedef enum logic [1:0] {
        VAR_QUAD_STEP     = 2'd0,
        VAR_DOUBLE_STEP   = 2'd1,
        VAR_DOUBLE_FLOOR4 = 2'd2,
        VAR_UNIT_FLOOR2   = 2'd3
    } variant_e;

    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [RATIO_W-1:0] ratio_t;

    // Active ratio and position inside the current output period
    typedef struct packed {
        ratio_t ratio;
        ratio_t cnt;
    } phase_t;

    // Length of the high phase: ceil(ratio / 2)
    function automatic ratio_t high_len(ratio_t r);
        logic [RATIO_W:0] t;
        t = {1'b0, r} + {{RATIO_W{1'b0}}, 1'b1};
        return ratio_t'(t >> 1);
    endfunction

endpackage

// File: rtl/cdiv_ratio_map.sv
module cdiv_ratio_map
    import cdiv_pkg::*;
#(
    parameter variant_e VARIANT = VAR_QUAD_STEP
) (
    input  sel_t   sel_i,
    output ratio_t ratio_o
);

    localparam ratio_t ONE = ratio_t'(1);

    ratio_t step;
    logic   low_code;

    assign step     = ratio_t'(sel_i) + ONE;
    assign low_code = (sel_i <= sel_t'(1));

    generate
        case (VARIANT)
            VAR_QUAD_STEP: begin : g_quad
                assign ratio_o = ratio_t'(step << 2);
            end
            VAR_DOUBLE_STEP: begin : g_double
                assign ratio_o = ratio_t'(step << 1);
            end
            VAR_DOUBLE_FLOOR4: begin : g_double_floor
                assign ratio_o = low_code ? ratio_t'(4) : ratio_t'(step << 1);
            end
            default: begin : g_unit_floor
                assign ratio_o = low_code ? ratio_t'(2) : step;
            end
        endcase
    endgenerate

    always_comb begin
        if (!$isunknown(sel_i)) begin
            AST_RATIO_MIN: assert (ratio_o >= ratio_t'(2))
                else $error("mapped ratio below two"); // R4
        end
    end

    generate
        if (VARIANT != VAR_UNIT_FLOOR2) begin : g_even_chk
            always_comb begin
                if (!$isunknown(sel_i)) begin
                    AST_RATIO_EVEN: assert (ratio_o[0] == 1'b0)
                        else $error("odd ratio in an even-only mapping"); // R5
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cdiv_phase_ctr.sv
module cdiv_phase_ctr
    import cdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  ratio_t next_ratio_i,
    output phase_t phase_o
);

    phase_t st;
    logic   wrap;

    assign wrap    = (st.cnt == st.ratio - ratio_t'(1));
    assign phase_o = st;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st.ratio <= next_ratio_i;
            st.cnt   <= '0;
        end else if (wrap) begin
            st.ratio <= next_ratio_i;
            st.cnt   <= '0;
        end else begin
            st.cnt   <= st.cnt + ratio_t'(1);
        end
    end

    AST_CNT_BELOW_RATIO: assert property (@(posedge clk_i) disable iff (rst_i)
        st.cnt < st.ratio)
        else $error("phase count reached the ratio"); // R8

    AST_RATIO_HELD: assert property (@(posedge clk_i) disable iff (rst_i)
        !wrap |=> $stable(st.ratio))
        else $error("ratio changed inside a period"); // R8

endmodule

// File: rtl/cdiv_wave_gen.sv
module cdiv_wave_gen
    import cdiv_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_i,
    input  phase_t phase_i,
    output logic   div_o
);

    ratio_t hi_len;
    logic   div_q;

    assign hi_len = high_len(phase_i.ratio);
    assign div_o  = div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            div_q <= 1'b0;
        end else begin
            div_q <= (phase_i.cnt < hi_len);
        end
    end

    AST_LOW_IN_RESET: assert property (@(posedge clk_i)
        rst_i |=> !div_o)
        else $error("output high after a reset edge"); // R6

    AST_RISE_AT_START: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(div_o) |-> (phase_i.cnt == ratio_t'(1)))
        else $error("output rose away from period start"); // R9

endmodule

// File: rtl/code_div_clk.sv
module code_div_clk
    import cdiv_pkg::*;
#(
    parameter variant_e VARIANT = VAR_QUAD_STEP
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [2:0] sel_code_i,
    output logic       clk_div_o
);

    ratio_t mapped_ratio;
    phase_t phase;

    cdiv_ratio_map #(.VARIANT(VARIANT)) u_map (
        .sel_i   (sel_t'(sel_code_i)),
        .ratio_o (mapped_ratio)
    );

    cdiv_phase_ctr u_ctr (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .next_ratio_i (mapped_ratio),
        .phase_o      (phase)
    );

    cdiv_wave_gen u_wave (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .phase_i (phase),
        .div_o   (clk_div_o)
    );

endmodule

// File: tb/code_div_clk_tb.sv
module code_div_clk_tb;
    import cdiv_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] sel = 3'd0;
    logic [3:0] outs;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    code_div_clk #(.VARIANT(VAR_QUAD_STEP))     u_dut_a (.clk_i(clk), .rst_i(rst), .sel_code_i(sel), .clk_div_o(outs[0]));
    code_div_clk #(.VARIANT(VAR_DOUBLE_STEP))   u_dut_b (.clk_i(clk), .rst_i(rst), .sel_code_i(sel), .clk_div_o(outs[1]));
    code_div_clk #(.VARIANT(VAR_DOUBLE_FLOOR4)) u_dut_c (.clk_i(clk), .rst_i(rst), .sel_code_i(sel), .clk_div_o(outs[2]));
    code_div_clk #(.VARIANT(VAR_UNIT_FLOOR2))   u_dut   (.clk_i(clk), .rst_i(rst), .sel_code_i(sel), .clk_div_o(outs[3]));

    // {instance[20:19], code[18:16], high[15:10], low[9:4], requirement[3:0]}
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {2'd0, 3'd0, 6'd2,  6'd2,  4'd1},   // R1
        {2'd0, 3'd3, 6'd8,  6'd8,  4'd1},   // R1
        {2'd0, 3'd7, 6'd16, 6'd16, 4'd1},   // R1
        {2'd1, 3'd0, 6'd1,  6'd1,  4'd2},   // R2
        {2'd1, 3'd5, 6'd6,  6'd6,  4'd2},   // R2
        {2'd1, 3'd7, 6'd8,  6'd8,  4'd2},   // R2
        {2'd2, 3'd0, 6'd2,  6'd2,  4'd3},   // R3
        {2'd2, 3'd1, 6'd2,  6'd2,  4'd3},   // R3
        {2'd2, 3'd2, 6'd3,  6'd3,  4'd3},   // R3
        {2'd2, 3'd7, 6'd8,  6'd8,  4'd3},   // R3
        {2'd3, 3'd0, 6'd1,  6'd1,  4'd4},   // R4
        {2'd3, 3'd1, 6'd1,  6'd1,  4'd4},   // R4
        {2'd3, 3'd2, 6'd2,  6'd1,  4'd5},   // R5 odd ratio 3
        {2'd3, 3'd4, 6'd3,  6'd2,  4'd5},   // R5 odd ratio 5
        {2'd3, 3'd6, 6'd4,  6'd3,  4'd5},   // R5 odd ratio 7
        {2'd3, 3'd7, 6'd4,  6'd4,  4'd4}    // R4
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(input int i);
        do @(negedge clk); while (outs[i] !== 1'b0);
        do @(negedge clk); while (outs[i] !== 1'b1);
    endtask

    // Starts on a sample where outs[i] has just risen; ends on the next rise
    task automatic measure(input int i, input int ehi, input int elo, input string req);
        int hi = 1;
        int lo = 1;
        @(negedge clk);
        while (outs[i] === 1'b1) begin hi++; @(negedge clk); end
        @(negedge clk);
        while (outs[i] === 1'b0) begin lo++; @(negedge clk); end
        check(hi == ehi, {req, " high phase"}, hi, ehi);
        check(lo == elo, {req, " low phase"}, lo, elo);
    endtask

    initial begin
        // R6: low during reset, regardless of code
        repeat (3) @(negedge clk);
        check(outs == 4'b0000, "R6 reset", int'(outs), 0);
        sel = 3'd5;
        @(negedge clk);
        check(outs == 4'b0000, "R6 code change in reset", int'(outs), 0);
        sel = 3'd7;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R7: first edge after release raises every output; code 7 applies
        @(negedge clk);
        check(outs == 4'b1111, "R7 first edge", int'(outs), 15);
        measure(3, 4, 4, "R7 first period");

        // R1..R5 vector walk
        for (int k = 0; k < NV; k++) begin
            int inst;
            string tag;
            inst = int'(VEC[k][20:19]);
            sel  = VEC[k][18:16];
            tag  = $sformatf("R%0d vec%0d", VEC[k][3:0], k);
            wait_rise(inst);
            wait_rise(inst);
            measure(inst, int'(VEC[k][15:10]), int'(VEC[k][9:4]), tag);
        end

        // R8: change at the start of a period; old period completes
        sel = 3'd7;
        wait_rise(3);
        wait_rise(3);
        sel = 3'd2;
        measure(3, 4, 4, "R8 old period kept");
        measure(3, 2, 1, "R8 new ratio next period");

        // R8: change on the last cycle of a period applies to the next one
        sel = 3'd7;
        wait_rise(3);
        wait_rise(3);
        repeat (3) @(negedge clk);
        check(outs[3] == 1'b1, "R8 high phase end", int'(outs[3]), 1);
        repeat (3) @(negedge clk);
        check(outs[3] == 1'b0, "R8 low phase", int'(outs[3]), 0);
        sel = 3'd0;
        @(negedge clk);
        check(outs[3] == 1'b0, "R8 last old cycle", int'(outs[3]), 0);
        @(negedge clk);
        check(outs[3] == 1'b1, "R8 boundary rise", int'(outs[3]), 1);
        measure(3, 1, 1, "R8 late change");

        // R6: reset in the middle of a high phase; R7 restart
        sel = 3'd7;
        wait_rise(0);
        rst = 1'b1;
        @(negedge clk);
        check(outs == 4'b0000, "R6 mid-run reset", int'(outs), 0);
        rst = 1'b0;
        @(negedge clk);
        check(outs == 4'b1111, "R7 restart", int'(outs), 15);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule